// File: doc/BRIEF.md
# Selectable-Order Sinc Decimator

This block converts a one-bit pulse-density bitstream, as produced by a delta-sigma modulator, into PCM words. It keeps up to three cascaded integrators running on every bit. At the end of each decimation period it samples the integrator that matches the selected order and passes the sample through up to three comb differences. The result is a first-, second- or third-order sinc output. All filter arithmetic is modulo 2^27.

Bits can come from a bitstream input that is sampled on every system clock. They can also come from an external clock and data pair. That pair is synchronized into the system domain, and one bit is taken on each rising edge of the external clock.

A raw mode bypasses the filter and packs 32 consecutive bits into a word. Each new word is registered. A one-cycle strobe announces it, and a ready flag stays up until the consumer acknowledges it. If a word arrives before the previous one was acknowledged, a sticky overrun flag is set.

Top module: `sinc_decim`

## Requirements
- R1: With `mode`=1 (first order) each result is the number of 1 bits among the N ticks of one period, so an all-ones stream gives N.
- R2: With `mode`=2 the result is (ones per period)·N, and with `mode`=3 it is (ones per period)·N². Full scale is therefore N² and N³, so N=500 third order with a 50% stream gives 62,500,000.
- R3: Integrators and combs wrap modulo 2^27. The result is zero-extended to 32 bits, so N=600 third order on all ones gives 216,000,000 mod 2^27 = 81,782,272.
- R4: After reset, or after a configuration change, no strobe is issued until k full periods under the new settings have elapsed (k = selected order, 1 in raw mode). From reset with internal bits, the first strobe follows the k·N-th clock.
- R5: A new `mode` or `period` is adopted only at the next period boundary, and that boundary produces no strobe. `period`=0 behaves as 1.
- R6: With `ext_sel`=0, one bit of `int_bit` is taken on every clock.
- R7: With `ext_sel`=1, `ext_bclk` and `ext_data` pass through a two-stage synchronizer, and one data bit is taken per rising edge of the synchronized clock.
- R8: With `mode`=0 (raw) a word is produced every 32 ticks regardless of `period`. The oldest bit is in bit 31 and the newest in bit 0.
- R9: `result` holds its value between strobes. `res_ready` rises with each strobe and clears on `rd_ack`. A strobe that arrives while `res_ready` is set without `rd_ack` sets `overrun`, which stays set until reset.
- R10: During reset `result`, `res_stb`, `res_ready` and `overrun` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | 0 raw, 1/2/3 filter order |
| period | input | 16 | Decimation period N in bit ticks (0 means 1) |
| ext_sel | input | 1 | 1 selects the external clock/data pair |
| ext_bclk | input | 1 | External bit clock, asynchronous |
| ext_data | input | 1 | External bitstream data |
| int_bit | input | 1 | Bitstream sampled every system clock |
| rd_ack | input | 1 | Consumer acknowledges the held result |
| result | output | 32 | Latest filtered value or raw word |
| res_stb | output | 1 | One-cycle pulse when `result` is updated |
| res_ready | output | 1 | Result not yet acknowledged |
| overrun | output | 1 | Sticky: a result was overwritten unread |

## Verification
The filter is driven with periodic bit patterns whose period divides N. For such patterns every N-tick window holds the same number of ones, so the correct value for each order is exact and independent of alignment. Distinct duty patterns separate the three orders and catch wrong integrator taps. All-ones streams at large N expose missing 27-bit wrap. The latency from reset to the first strobe distinguishes the settle counts, and a mid-run change of order and period checks that the boundary is deferred. Fixed random words in raw mode expose bit-order errors. The external pair is exercised with a slow clock so that only rising edges may count.

// File: rtl/sinc_pkg.sv
package sinc_pkg;
  typedef enum logic [1:0] {
    MODE_RAW = 2'd0,
    MODE_S1  = 2'd1,
    MODE_S2  = 2'd2,
    MODE_S3  = 2'd3
  } mode_t;
  localparam int MAX_ORDER = 3;
endpackage

// File: rtl/sinc_front.sv
module sinc_front #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ext_sel,
  input  logic ext_bclk,
  input  logic ext_data,
  input  logic int_bit,
  output logic tick,
  output logic bit_o
);
  logic [SYNC-1:0] clk_sy;
  logic [SYNC-1:0] dat_sy;
  logic            clk_last;
  logic            rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_sy   <= '0;
      dat_sy   <= '0;
      clk_last <= 1'b0;
    end else begin
      clk_sy   <= {clk_sy[SYNC-2:0], ext_bclk};
      dat_sy   <= {dat_sy[SYNC-2:0], ext_data};
      clk_last <= clk_sy[SYNC-1];
    end
  end

  assign rise  = clk_sy[SYNC-1] & ~clk_last;
  assign tick  = ext_sel ? rise : 1'b1;
  assign bit_o = ext_sel ? dat_sy[SYNC-1] : int_bit;

  // R7
  edge_single_chk: assert property (@(posedge clk) disable iff (rst)
    (ext_sel && tick) |=> (!ext_sel || !tick));
endmodule

// File: rtl/sinc_integ.sv
module sinc_integ #(
  parameter int W     = 27,
  parameter int ORDER = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      tick,
  input  logic                      bit_i,
  output logic [ORDER-1:0][W-1:0]   acc_nxt
);
  logic [ORDER-1:0][W-1:0] acc;

  for (genvar s = 0; s < ORDER; s++) begin : g_stage
    if (s == 0) begin : g_first
      assign acc_nxt[s] = acc[s] + W'(bit_i);
    end else begin : g_rest
      assign acc_nxt[s] = acc[s] + acc_nxt[s-1];
    end
    always_ff @(posedge clk) begin
      if (rst)       acc[s] <= '0;
      else if (tick) acc[s] <= acc_nxt[s];
    end
  end

  // R6
  first_stage_step_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(acc[0]));
endmodule

// File: rtl/sinc_comb.sv
module sinc_comb #(
  parameter int W     = 27,
  parameter int ORDER = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [1:0]   order,
  input  logic [W-1:0] samp,
  output logic [W-1:0] y
);
  logic [ORDER-1:0][W-1:0] dly;
  logic [ORDER-1:0][W-1:0] diff;

  for (genvar s = 0; s < ORDER; s++) begin : g_comb
    if (s == 0) begin : g_first
      assign diff[s] = samp - dly[s];
      always_ff @(posedge clk) begin
        if (rst)       dly[s] <= '0;
        else if (load) dly[s] <= samp;
      end
    end else begin : g_rest
      assign diff[s] = diff[s-1] - dly[s];
      always_ff @(posedge clk) begin
        if (rst)       dly[s] <= '0;
        else if (load) dly[s] <= diff[s-1];
      end
    end
  end

  always_comb begin
    y = diff[0];
    for (int i = 1; i < ORDER; i++)
      if (int'(order) == i + 1) y = diff[i];
  end
endmodule

// File: rtl/sinc_decim.sv
module sinc_decim
  import sinc_pkg::*;
#(
  parameter int ACC_W  = 27,
  parameter int PER_W  = 16,
  parameter int OUT_W  = 32,
  parameter int SYNC   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode,
  input  logic [PER_W-1:0] period,
  input  logic             ext_sel,
  input  logic             ext_bclk,
  input  logic             ext_data,
  input  logic             int_bit,
  input  logic             rd_ack,
  output logic [OUT_W-1:0] result,
  output logic             res_stb,
  output logic             res_ready,
  output logic             overrun
);
  localparam int RAW_LEN = OUT_W;

  logic tick, bit_s;
  logic [MAX_ORDER-1:0][ACC_W-1:0] acc_nxt;
  logic [ACC_W-1:0] samp, comb_y;
  logic [OUT_W-1:0] shreg, raw_word;

  mode_t            mode_req, mode_act;
  logic [PER_W-1:0] per_act, cnt, neff;
  logic [1:0]       settle, k_act, k_req, sel;
  logic             bnd, cfg_chg, emit;

  sinc_front #(.SYNC(SYNC)) u_front (
    .clk(clk), .rst(rst), .ext_sel(ext_sel), .ext_bclk(ext_bclk),
    .ext_data(ext_data), .int_bit(int_bit), .tick(tick), .bit_o(bit_s)
  );

  sinc_integ #(.W(ACC_W), .ORDER(MAX_ORDER)) u_integ (
    .clk(clk), .rst(rst), .tick(tick), .bit_i(bit_s), .acc_nxt(acc_nxt)
  );

  assign mode_req = mode_t'(mode);
  assign k_req    = (mode_req == MODE_RAW) ? 2'd1 : mode;
  assign k_act    = (mode_act == MODE_RAW) ? 2'd1 : 2'(mode_act);
  assign sel      = k_req - 2'd1;
  assign samp     = acc_nxt[sel];

  sinc_comb #(.W(ACC_W), .ORDER(MAX_ORDER)) u_comb (
    .clk(clk), .rst(rst), .load(bnd), .order(k_req), .samp(samp), .y(comb_y)
  );

  assign neff     = (mode_act == MODE_RAW) ? PER_W'(RAW_LEN) :
                    ((per_act == '0) ? PER_W'(1) : per_act);
  assign bnd      = tick && (cnt == neff - PER_W'(1));
  assign cfg_chg  = (mode_req != mode_act) || (period != per_act);
  assign emit     = bnd && !cfg_chg && ((3'(settle) + 3'd1) >= 3'(k_act));
  assign raw_word = {shreg[OUT_W-2:0], bit_s};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      mode_act  <= mode_req;
      per_act   <= period;
      settle    <= '0;
      shreg     <= '0;
      result    <= '0;
      res_stb   <= 1'b0;
      res_ready <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      res_stb <= 1'b0;
      if (tick) begin
        shreg <= raw_word;
        cnt   <= bnd ? '0 : cnt + PER_W'(1);
      end
      if (bnd) begin
        mode_act <= mode_req;
        per_act  <= period;
        if (cfg_chg)              settle <= '0;
        else if (settle != 2'd3)  settle <= settle + 2'd1;
      end
      if (emit) begin
        result    <= (mode_act == MODE_RAW) ? raw_word : OUT_W'(comb_y);
        res_stb   <= 1'b1;
        res_ready <= 1'b1;
        if (res_ready && !rd_ack) overrun <= 1'b1;
      end else if (rd_ack) begin
        res_ready <= 1'b0;
      end
    end
  end

  // R9
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);
  // R9
  stb_ready_chk: assert property (@(posedge clk) disable iff (rst)
    res_stb |-> res_ready);
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !res_stb |=> (res_stb || $stable(result)));
  // R3
  sinc_width_chk: assert property (@(posedge clk) disable iff (rst)
    (res_stb && mode_act != MODE_RAW) |-> (result[OUT_W-1:ACC_W] == '0));
  // R5
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt < neff);
endmodule

// File: tb/sinc_decim_test.sv
`timescale 1ns/1ps
module sinc_decim_test;
  logic        clk = 0;
  logic        rst = 1;
  logic [1:0]  mode = 2'd1;
  logic [15:0] period = 16'd4;
  logic        ext_sel = 0, ext_bclk = 0, ext_data = 0, int_bit = 0, rd_ack = 0;
  logic [31:0] result;
  logic        res_stb, res_ready, overrun;

  int nchk = 0, nfail = 0;
  logic [63:0] pat = '1;
  int plen = 1;
  int idx = 0, eidx = 0;
  logic [1:0] ph = 0;

  always #2 clk = ~clk;

  sinc_decim uut (
    .clk(clk), .rst(rst), .mode(mode), .period(period), .ext_sel(ext_sel),
    .ext_bclk(ext_bclk), .ext_data(ext_data), .int_bit(int_bit), .rd_ack(rd_ack),
    .result(result), .res_stb(res_stb), .res_ready(res_ready), .overrun(overrun)
  );

  function automatic logic patbit(int i);
    return pat[plen - 1 - (i % plen)];
  endfunction

  function automatic int popc();
    int c = 0;
    for (int i = 0; i < plen; i++) c += int'(pat[i]);
    return c;
  endfunction

  function automatic longint expv(int k, int n);
    longint v = longint'(popc()) * n / plen;
    for (int i = 1; i < k; i++) v = v * n;
    return v % 64'd134217728;
  endfunction

  initial begin
    forever begin
      @(negedge clk);
      int_bit = patbit(idx);
      ph = ph + 2'd1;
      if (ph[1] && !ext_bclk) begin
        ext_bclk = 1; eidx = eidx + 1;
      end else if (!ph[1] && ext_bclk) begin
        ext_bclk = 0; ext_data = patbit(eidx);
      end
      @(posedge clk); #1;
      if (rst) begin idx = 0; eidx = 0; end
      else idx = idx + 1;
    end
  end

  initial begin
    #(4 * 190000);
    nfail++;
    $display("FAIL watchdog R4 act=timeout exp=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
  endtask

  task automatic wait_stb(output int n, output bit ok);
    n = 0; ok = 0;
    while (n < 5000) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (res_stb) begin ok = 1; break; end
    end
    if (!ok) chk(0, "R4 strobe timeout", n, 0);
  endtask

  task automatic run(input int k, input int n, input logic [63:0] p, input int pl,
                     input bit ext, input int nres, input bit lat, input string req);
    int c; bit ok; int neff;
    mode = 2'(k); period = 16'(n); pat = p; plen = pl; ext_sel = ext;
    neff = (n == 0) ? 1 : n;
    do_reset();
    wait_stb(c, ok);
    if (lat) chk(c == k * neff, {req, " R4 latency"}, c, k * neff);
    for (int i = 0; i < nres; i++) begin
      if (i > 0) wait_stb(c, ok);
      chk(longint'(result) == expv(k, neff), req, result, expv(k, neff));
    end
  endtask

  initial begin
    int c; bit ok;
    logic [63:0] w;
    void'($urandom(32'd1234));

    // R10 reset state
    rst = 1;
    repeat (4) @(negedge clk);
    chk(result == 0 && !res_stb && !res_ready && !overrun, "R10 reset", result, 0);

    // R1 / R6 first order
    run(1, 10, 64'b10110, 5, 0, 3, 1, "R1 sinc1 duty");
    run(1, 12, 64'h1, 1, 0, 2, 1, "R1 sinc1 full");
    // R5 period zero behaves as one
    run(1, 0, 64'h1, 1, 0, 4, 1, "R5 period0");
    // R2 higher orders
    run(2, 12, 64'h1, 1, 0, 2, 1, "R2 sinc2 full");
    run(2, 16, 64'b1000, 4, 0, 2, 1, "R2 sinc2 quarter");
    run(3, 500, 64'b10, 2, 0, 2, 1, "R2 sinc3 mid");
    chk(result == 32'd62500000, "R2 sinc3 midscale", result, 62500000);
    // R3 wrap
    run(3, 600, 64'h1, 1, 0, 1, 1, "R3 wrap");
    chk(result == 32'd81782272, "R3 wrap value", result, 81782272);

    // R5 / R4 deferred change
    run(2, 16, 64'b10, 2, 0, 1, 0, "R5 before change");
    mode = 2'd3; period = 16'd10;
    wait_stb(c, ok);
    chk(c == 46, "R5 change gap", c, 46);
    chk(result == 32'd500, "R5 new cfg value", result, 500);

    // R8 raw words, period ignored
    w = {$urandom, $urandom};
    mode = 2'd0; period = 16'd7; pat = w; plen = 64; ext_sel = 0;
    do_reset();
    wait_stb(c, ok);
    chk(c == 32, "R8 raw latency", c, 32);
    chk(result == w[63:32], "R8 raw word1", result, w[63:32]);
    wait_stb(c, ok);
    chk(c == 32 && result == w[31:0], "R8 raw word2", result, w[31:0]);

    // R7 external clock/data
    run(2, 8, 64'b1100, 4, 1, 3, 0, "R7 ext sinc2");
    run(1, 6, 64'b011, 3, 1, 2, 0, "R7 ext sinc1");

    // R9 ready / overrun
    rd_ack = 0;
    run(1, 4, 64'b1000, 4, 0, 1, 1, "R9 first");
    chk(res_ready && !overrun, "R9 ready set", {res_ready, overrun}, 2);
    @(posedge clk); @(negedge clk);
    chk(result == 1, "R9 hold", result, 1);
    wait_stb(c, ok);
    chk(overrun == 1, "R9 overrun set", overrun, 1);
    rd_ack = 1;
    @(posedge clk); @(negedge clk);
    rd_ack = 0;
    chk(!res_ready && overrun, "R9 ack clears ready", {res_ready, overrun}, 1);

    // random periodic patterns
    for (int it = 0; it < 8; it++) begin
      int pl2, n2, k2;
      logic [63:0] p2;
      pl2 = 1 << ($urandom % 4);
      n2 = pl2 * (1 + $urandom % 8);
      k2 = 1 + $urandom % 3;
      p2 = {$urandom, $urandom};
      run(k2, n2, p2, pl2, 0, 2, 1, "R2 random");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule